// File: doc/BRIEF.md
# Four-Channel Lock-Step Direct Digital Synthesizer

This block generates four sampled sine waves from a single sample clock. Every channel owns a 32-bit phase accumulator that advances by its frequency word on each clock. A 14-bit phase offset is added to the top of the accumulator. The offset phase then addresses a quarter-wave sine table that is mirrored into a full period. A 10-bit amplitude word scales the result. The block emits one unsigned 10-bit sample per channel per clock.

A separate register block drives the control words for all four channels and raises a shared apply strobe to make them active. All channels are clocked and updated in lock step. A synchronous clear zeroes every accumulator on the same edge, so the channels restart phase-aligned. The frequency, phase and amplitude paths are padded so that a change on any of them shows up at the output after the same number of clock edges.

Top module: `dds_quad_core`

## Requirements
- R1: While reset is held and after its release, with no apply strobe, every channel's sample equals mid-scale, 512.
- R2: Control words are taken into the active set only on a clock edge where `apply_i` is high. At other times, changes on the word inputs have no effect on any output.
- R3: Each channel's 32-bit accumulator adds its active frequency word on every clock edge and wraps modulo 2^32.
- R4: The table phase is (accumulator bits 31:18 + active phase offset) modulo 2^14.
- R5: Phase bits 13:12 select the quadrant and bits 11:6 give an index i. The table row is k = i in quadrants 0 and 2, and k = 63 - i in quadrants 1 and 3. The magnitude is floor(k*(126-k)*511/3969). The signed sine is positive in quadrants 0 and 1 and negative in quadrants 2 and 3. Phase bits 5:0 do not affect the sample.
- R6: The sample is floor(sine*amp/1024) + 512, written as unsigned offset binary. An amplitude word of zero gives 512.
- R7: A frequency, phase or amplitude word made active on clock edge E0 first affects the sample after edge E4. The sample after edge E3 still reflects the previous words.
- R8: A clear on edge Ec zeroes all four accumulators on that edge and takes priority over the add. The sample after Ec+3 corresponds to phase (0 + offset). The sample after Ec+4 corresponds to phase (top bits of the frequency word + offset).
- R9: Each channel's words affect only that channel's sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Synchronous clear of all four accumulators |
| apply_i | input | 1 | Makes the presented control words active on this edge |
| ftw_i | input | 128 | Frequency words, channel n in bits [32n+31:32n] |
| pow_i | input | 56 | Phase offsets, channel n in bits [14n+13:14n] |
| asf_i | input | 40 | Amplitude words, channel n in bits [10n+9:10n] |
| sample_o | output | 40 | Output samples, channel n in bits [10n+9:10n] |

## Verification
Every result is due four clock edges after the edge that sampled `apply_i`. The bench therefore pulses the strobe and samples on the falling edge that follows the fourth rising edge. For the latency checks it also samples one edge earlier, to confirm that the old value is still present. After a clear, mid-scale for a zero offset is due three edges later, and each further edge shows one more frequency step. The bench samples once per falling edge across that run. When frequency words are zero the phase is static, so the vector table holds hand-computed samples. Running waves are compared against a model of the R5 and R6 formulas, indexed by the edge count.

// File: rtl/dds_pkg.sv
package dds_pkg;

  // Register stages between the active control set and the sample register.
  localparam int ACC_LAT = 1;  // accumulator register
  localparam int PH_LAT  = 1;  // offset phase register
  localparam int LUT_LAT = 1;  // sine register

  // Quarter-wave magnitude: parabolic fit from 0 at k=0 to full scale at k=qmax.
  function automatic int quarter_mag(input int k, input int aw, input int ow);
    int qmax;
    int peak;
    qmax = (1 << aw) - 1;
    peak = (1 << (ow - 1)) - 1;
    return (k * (2 * qmax - k) * peak) / (qmax * qmax);
  endfunction

endpackage

// File: rtl/dds_delay_line.sv
module dds_delay_line #(
  parameter int W     = 8,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stage_q [DEPTH];
  logic [W-1:0] stage_d [DEPTH];

  always_comb begin
    stage_d[0] = d_i;
    for (int i = 1; i < DEPTH; i++) begin
      stage_d[i] = stage_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        stage_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        stage_q[i] <= stage_d[i];
      end
    end
  end

  assign q_o = stage_q[DEPTH-1];

endmodule

// File: rtl/dds_ctrl_align.sv
module dds_ctrl_align #(
  parameter int FTW_W   = 32,
  parameter int POW_W   = 14,
  parameter int ASF_W   = 10,
  parameter int POW_DLY = 1,
  parameter int ASF_DLY = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             apply_i,
  input  logic [FTW_W-1:0] ftw_i,
  input  logic [POW_W-1:0] pow_i,
  input  logic [ASF_W-1:0] asf_i,
  output logic [FTW_W-1:0] ftw_o,
  output logic [POW_W-1:0] pow_o,
  output logic [ASF_W-1:0] asf_o
);

  logic [FTW_W-1:0] ftw_q, ftw_d;
  logic [POW_W-1:0] pow_q, pow_d;
  logic [ASF_W-1:0] asf_q, asf_d;

  // Active set: load enable is the apply strobe.
  always_comb begin
    ftw_d = ftw_q;
    pow_d = pow_q;
    asf_d = asf_q;
    if (apply_i) begin
      ftw_d = ftw_i;
      pow_d = pow_i;
      asf_d = asf_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ftw_q <= '0;
      pow_q <= '0;
      asf_q <= '0;
    end else begin
      ftw_q <= ftw_d;
      pow_q <= pow_d;
      asf_q <= asf_d;
    end
  end

  assign ftw_o = ftw_q;

  // Pad the offset and amplitude paths to meet the data at its stage.
  dds_delay_line #(.W(POW_W), .DEPTH(POW_DLY)) u_pow_dly (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  (pow_q),
    .q_o  (pow_o)
  );

  dds_delay_line #(.W(ASF_W), .DEPTH(ASF_DLY)) u_asf_dly (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  (asf_q),
    .q_o  (asf_o)
  );

  p_hold_when_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !apply_i |=> ($stable(ftw_q) && $stable(pow_q) && $stable(asf_q)));

  p_load_on_apply_r2: assert property (@(posedge clk) disable iff (!rst_n)
    apply_i |=> (ftw_q == $past(ftw_i) && asf_q == $past(asf_i)));

endmodule

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
  parameter int FTW_W = 32,
  parameter int POW_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic [FTW_W-1:0] ftw_i,
  input  logic [POW_W-1:0] pow_i,
  output logic [POW_W-1:0] phase_o
);

  logic [FTW_W-1:0] acc_q, acc_d;
  logic [POW_W-1:0] ph_q, ph_d;

  always_comb begin
    if (clr_i) begin
      acc_d = '0;
    end else begin
      acc_d = acc_q + ftw_i;
    end
    ph_d = acc_q[FTW_W-1 -: POW_W] + pow_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      ph_q  <= '0;
    end else begin
      acc_q <= acc_d;
      ph_q  <= ph_d;
    end
  end

  assign phase_o = ph_q;

  p_clear_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (acc_q == '0));

  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> (acc_q == FTW_W'($past(acc_q) + $past(ftw_i))));

  p_offset_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (ph_q == POW_W'($past(acc_q[FTW_W-1 -: POW_W]) + $past(pow_i))));

endmodule

// File: rtl/dds_sine_lut.sv
module dds_sine_lut #(
  parameter int POW_W  = 14,
  parameter int LUT_AW = 6,
  parameter int OUT_W  = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [POW_W-1:0]        phase_i,
  output logic signed [OUT_W-1:0] sine_o
);

  localparam int QN     = 1 << LUT_AW;
  localparam int MAG_W  = OUT_W - 1;
  localparam int DROP_W = POW_W - 2 - LUT_AW;

  logic [MAG_W-1:0]        rom [QN];
  logic [1:0]              quad;
  logic [LUT_AW-1:0]       idx;
  logic [LUT_AW-1:0]       row;
  logic signed [OUT_W-1:0] mag_s;
  logic signed [OUT_W-1:0] sine_d, sine_q;
  logic                    phase_lsb_unused;

  // Quarter-wave table built at elaboration.
  for (genvar k = 0; k < QN; k++) begin : g_rom
    assign rom[k] = MAG_W'(dds_pkg::quarter_mag(k, LUT_AW, OUT_W));
  end

  assign quad             = phase_i[POW_W-1 -: 2];
  assign idx              = phase_i[POW_W-3 -: LUT_AW];
  assign phase_lsb_unused = ^phase_i[DROP_W-1:0];

  always_comb begin
    row    = quad[0] ? ~idx : idx;
    mag_s  = $signed({1'b0, rom[row]});
    sine_d = quad[1] ? -mag_s : mag_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sine_q <= '0;
    end else begin
      sine_q <= sine_d;
    end
  end

  assign sine_o = sine_q;

  p_no_min_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sine_q != {1'b1, {(OUT_W-1){1'b0}}});

  p_sign_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (quad[1] && rst_n) |=> !(sine_q > 0));

endmodule

// File: rtl/dds_amp_scale.sv
module dds_amp_scale #(
  parameter int ASF_W = 10,
  parameter int OUT_W = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic signed [OUT_W-1:0] sine_i,
  input  logic [ASF_W-1:0]        asf_i,
  output logic [OUT_W-1:0]        sample_o
);

  localparam int PROD_W = OUT_W + ASF_W + 1;
  localparam logic [OUT_W-1:0] MID = {1'b1, {(OUT_W-1){1'b0}}};

  logic signed [PROD_W-1:0] prod_s;
  logic signed [OUT_W-1:0]  scaled;
  logic [OUT_W-1:0]         sample_d, sample_q;
  logic                     prod_spare_unused;

  always_comb begin
    prod_s   = sine_i * $signed({1'b0, asf_i});
    scaled   = prod_s[ASF_W +: OUT_W];
    sample_d = {~scaled[OUT_W-1], scaled[OUT_W-2:0]};
  end

  assign prod_spare_unused = prod_s[PROD_W-1] ^ (^prod_s[ASF_W-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sample_q <= MID;
    end else begin
      sample_q <= sample_d;
    end
  end

  assign sample_o = sample_q;

  p_zero_amp_mid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (asf_i == '0) |=> (sample_q == MID));

  p_zero_sine_mid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sine_i == '0) |=> (sample_q == MID));

endmodule

// File: rtl/dds_quad_core.sv
module dds_quad_core #(
  parameter int NUM_CH = 4,
  parameter int FTW_W  = 32,
  parameter int POW_W  = 14,
  parameter int ASF_W  = 10,
  parameter int OUT_W  = 10,
  parameter int LUT_AW = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clear_i,
  input  logic                      apply_i,
  input  logic [NUM_CH*FTW_W-1:0]   ftw_i,
  input  logic [NUM_CH*POW_W-1:0]   pow_i,
  input  logic [NUM_CH*ASF_W-1:0]   asf_i,
  output logic [NUM_CH*OUT_W-1:0]   sample_o
);

  // Offset joins one register after the accumulator; amplitude joins
  // after accumulator, phase and sine registers.
  localparam int POW_DLY = dds_pkg::ACC_LAT;
  localparam int ASF_DLY = dds_pkg::ACC_LAT + dds_pkg::PH_LAT + dds_pkg::LUT_LAT;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic [FTW_W-1:0]        ftw_act;
    logic [POW_W-1:0]        pow_al;
    logic [ASF_W-1:0]        asf_al;
    logic [POW_W-1:0]        phase;
    logic signed [OUT_W-1:0] sine;

    dds_ctrl_align #(
      .FTW_W  (FTW_W),
      .POW_W  (POW_W),
      .ASF_W  (ASF_W),
      .POW_DLY(POW_DLY),
      .ASF_DLY(ASF_DLY)
    ) u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .apply_i(apply_i),
      .ftw_i  (ftw_i[ch*FTW_W +: FTW_W]),
      .pow_i  (pow_i[ch*POW_W +: POW_W]),
      .asf_i  (asf_i[ch*ASF_W +: ASF_W]),
      .ftw_o  (ftw_act),
      .pow_o  (pow_al),
      .asf_o  (asf_al)
    );

    dds_phase_acc #(
      .FTW_W(FTW_W),
      .POW_W(POW_W)
    ) u_acc (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (clear_i),
      .ftw_i  (ftw_act),
      .pow_i  (pow_al),
      .phase_o(phase)
    );

    dds_sine_lut #(
      .POW_W (POW_W),
      .LUT_AW(LUT_AW),
      .OUT_W (OUT_W)
    ) u_lut (
      .clk    (clk),
      .rst_n  (rst_n),
      .phase_i(phase),
      .sine_o (sine)
    );

    dds_amp_scale #(
      .ASF_W(ASF_W),
      .OUT_W(OUT_W)
    ) u_amp (
      .clk     (clk),
      .rst_n   (rst_n),
      .sine_i  (sine),
      .asf_i   (asf_al),
      .sample_o(sample_o[ch*OUT_W +: OUT_W])
    );
  end

endmodule

// File: tb/dds_quad_core_bench.sv
module dds_quad_core_bench;

  logic         clk;
  logic         rst_n;
  logic         clear_i;
  logic         apply_i;
  logic [127:0] ftw_i;
  logic [55:0]  pow_i;
  logic [39:0]  asf_i;
  logic [39:0]  sample_o;

  logic [31:0] ftw_v [4];
  logic [13:0] pow_v [4];
  logic [9:0]  asf_v [4];

  int n_run;
  int n_fail;
  bit finished;

  always_comb begin
    for (int c = 0; c < 4; c++) begin
      ftw_i[c*32 +: 32] = ftw_v[c];
      pow_i[c*14 +: 14] = pow_v[c];
      asf_i[c*10 +: 10] = asf_v[c];
    end
  end

  dds_quad_core u_dds_quad_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (clear_i),
    .apply_i (apply_i),
    .ftw_i   (ftw_i),
    .pow_i   (pow_i),
    .asf_i   (asf_i),
    .sample_o(sample_o)
  );

  initial clk = 1'b0;
  always #5ns clk = ~clk;

  typedef struct packed {
    logic [13:0] pw;
    logic [9:0]  am;
    logic [9:0]  ex;
  } vec_t;

  // Four rows of four channels; frequency words are zero, so phase = offset.
  localparam vec_t TBL [16] = '{
    '{14'h0000, 10'd1023, 10'd512}, '{14'h0FC0, 10'd1023, 10'd1022},
    '{14'h3000, 10'd1023, 10'd1},   '{14'h1000, 10'd512,  10'd767},
    '{14'h0800, 10'd1023, 10'd898}, '{14'h2800, 10'd1023, 10'd125},
    '{14'h1800, 10'd256,  10'd606}, '{14'h3000, 10'd512,  10'd256},
    '{14'h083F, 10'd1023, 10'd898}, '{14'h0FC0, 10'd0,    10'd512},
    '{14'h2000, 10'd1023, 10'd512}, '{14'h3FC0, 10'd1023, 10'd512},
    '{14'h083F, 10'd1023, 10'd898}, '{14'h0FC0, 10'd1023, 10'd1022},
    '{14'h2000, 10'd1023, 10'd512}, '{14'h3FC0, 10'd1023, 10'd512}
  };

  function automatic int smp(input int c);
    return int'(sample_o[c*10 +: 10]);
  endfunction

  // Model of the R5/R6 formulas.
  function automatic int model(input int p, input int a);
    int ph, quad, idx, k, mag, s;
    ph   = p & 16'h3FFF;
    quad = ph >> 12;
    idx  = (ph >> 6) & 63;
    k    = (quad & 1) ? 63 - idx : idx;
    mag  = (k * (126 - k) * 511) / 3969;
    s    = (quad & 2) ? -mag : mag;
    return ((s * a) >>> 10) + 512;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  // Strobe apply for one edge (E0); return after the falling edge past E3.
  task automatic apply_to_e3();
    @(negedge clk);
    apply_i = 1'b1;
    @(negedge clk);
    apply_i = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] fset [4];
    int          pre  [4];
    n_run    = 0;
    n_fail   = 0;
    finished = 1'b0;
    rst_n    = 1'b0;
    clear_i  = 1'b0;
    apply_i  = 1'b0;
    for (int c = 0; c < 4; c++) begin
      ftw_v[c] = '0;
      pow_v[c] = '0;
      asf_v[c] = '0;
    end
    repeat (3) @(negedge clk);
    for (int c = 0; c < 4; c++) check("R1 reset mid-scale", smp(c), 512);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    for (int c = 0; c < 4; c++) check("R1 idle after reset", smp(c), 512);

    // Vector table: R4, R5, R6 and R9 (row 3 changes channel 1 only).
    for (int r = 0; r < 4; r++) begin
      for (int c = 0; c < 4; c++) begin
        pow_v[c] = TBL[r*4+c].pw;
        asf_v[c] = TBL[r*4+c].am;
      end
      apply_to_e3();
      @(negedge clk);
      for (int c = 0; c < 4; c++)
        check("R5 R6 R9 table row", smp(c), int'(TBL[r*4+c].ex));
    end

    // R2: new words without apply must not reach the output.
    for (int c = 0; c < 4; c++) begin
      ftw_v[c] = 32'h1234_5678;
      pow_v[c] = 14'h2000;
      asf_v[c] = 10'd77;
    end
    repeat (8) @(negedge clk);
    for (int c = 0; c < 4; c++)
      check("R2 ignored without apply", smp(c), int'(TBL[12+c].ex));

    // R3 / R7: start running waves; the accumulators are still at zero.
    fset[0] = 32'h1000_0000;
    fset[1] = 32'h0800_0000;
    fset[2] = 32'h0000_0000;
    fset[3] = 32'hC000_0000;
    for (int c = 0; c < 4; c++) begin
      pre[c]   = smp(c);
      ftw_v[c] = fset[c];
      pow_v[c] = '0;
      asf_v[c] = 10'd1023;
    end
    apply_to_e3();
    for (int c = 0; c < 4; c++) check("R7 frequency old after E3", smp(c), pre[c]);
    for (int m = 4; m <= 7; m++) begin
      @(negedge clk);
      for (int c = 0; c < 4; c++) begin
        logic [31:0] a;
        a = fset[c] * 32'(m - 3);
        check("R3 R7 accumulate and wrap", smp(c), model(int'(a[31:18]), 1023));
      end
    end

    // R8: synchronous clear realigns all channels.
    @(negedge clk);
    clear_i = 1'b1;
    @(negedge clk);
    clear_i = 1'b0;
    repeat (3) @(negedge clk);
    for (int c = 0; c < 4; c++) check("R8 clear restarts phase", smp(c), 512);
    @(negedge clk);
    for (int c = 0; c < 4; c++)
      check("R8 first step after clear", smp(c), model(int'(fset[c][31:18]), 1023));

    // R7: phase and amplitude latency from a static phase.
    for (int c = 0; c < 4; c++) begin
      ftw_v[c] = '0;
      pow_v[c] = 14'h0800;
      asf_v[c] = 10'd1023;
    end
    apply_to_e3();
    @(negedge clk);
    clear_i = 1'b1;
    @(negedge clk);
    clear_i = 1'b0;
    repeat (5) @(negedge clk);
    check("R7 static start ch0", smp(0), 898);
    for (int c = 0; c < 4; c++) pow_v[c] = 14'h2800;
    apply_to_e3();
    check("R7 phase old after E3", smp(0), 898);
    @(negedge clk);
    check("R7 phase new after E4", smp(0), 125);
    check("R7 phase new after E4 ch2", smp(2), 125);
    for (int c = 0; c < 4; c++) asf_v[c] = 10'd512;
    apply_to_e3();
    check("R7 amplitude old after E3", smp(3), 125);
    @(negedge clk);
    check("R7 amplitude new after E4", smp(3), 318);
    check("R6 model agrees", smp(1), model(14'h2800, 512));

    finish_run();
  end

endmodule